// File: doc/BRIEF.md
# Interrupt-Triggered Transfer Engine

This block is a single-channel data mover that a peripheral's interrupt starts in place of the CPU. Software loads a mode word, a source address, a destination address and a transfer count through a small configuration write port, then sets the channel enable. Each request pulse from the peripheral then moves one unit: the engine reads it from the source address over a simple memory bus and writes it to the destination address. It then steps the addresses as the mode fields select and lowers the count by one.

After a transfer that leaves the count above zero, the engine pulses a flag-clear strobe back to the peripheral, and the CPU never sees that request. The transfer that brings the count to zero is handled differently. The clear strobe is withheld, so the peripheral flag stays set. The channel enable drops by itself, and the request is passed to the CPU interrupt output so that a handler can do the wrap-up. A request that finds the channel disabled goes straight to the CPU. A typical use drains a receive-data register at a fixed address into a run of consecutive RAM bytes.

Top module: `irq_xfer_engine`

## Requirements
- R1: After reset the channel enable, busy, memory read, memory write, flag-clear and CPU interrupt outputs are all 0, and the transfer count reads 0.
- R2: Each request serviced with the channel enabled performs exactly one memory read at the source address, followed by one memory write at the destination address. The write carries the data that was read. In byte size (mode bit 4 = 0), the write data holds the read data's low 8 bits with the upper bits zero and memWide = 0. In word size (bit 4 = 1), all 16 bits are written and memWide = 1.
- R3: The source address mode sits in mode bits [1:0] and the destination address mode in bits [3:2]. For each field, 00 or 01 keeps the address fixed, 10 adds the step after each transfer, and 11 subtracts the step. The step is 1 in byte size and 2 in word size.
- R4: Each transfer lowers the 16-bit transfer count by exactly one, two cycles after its write cycle.
- R5: After a transfer that leaves the count nonzero, flagClr pulses for exactly one cycle, cpuIrq stays 0 and the channel stays enabled.
- R6: After the transfer that brings the count to zero, flagClr does not pulse, cpuIrq pulses, and the channel enable reads 0 from the next cycle on.
- R7: A request taken while the channel enable is 0 raises cpuIrq for one cycle and causes no memory access and no flagClr.
- R8: A transfer runs through read, write and update cycles. busy is high for exactly those three consecutive cycles, memRe is asserted in the first of them and memWe in the second.
- R9: Requests that arrive while a transfer is in progress, or on consecutive cycles, are counted as pending, up to 15. Each one is serviced in turn after the current transfer, and the count-zero rule applies to each of them.
- R10: With the source fixed, the destination incrementing, byte size and a count of 128, 128 requests place the 128 successive source values into 128 consecutive destination bytes. Only the last of them reaches the CPU.
- R11: Configuration writes select their register with cfgSel: 0 for the mode (bits [4:0]), 1 for the source address, 2 for the destination address, 3 for the count and 4 for the enable (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Configuration register select |
| cfgData | input | 16 | Configuration write data |
| reqIn | input | 1 | Peripheral request, one request per high cycle |
| flagClr | output | 1 | One-cycle strobe that clears the peripheral flag |
| cpuIrq | output | 1 | Interrupt forwarded to the CPU |
| memRe | output | 1 | Memory read strobe; memRdata is sampled in the same cycle |
| memWe | output | 1 | Memory write strobe |
| memWide | output | 1 | Access size: 0 byte, 1 word |
| memAddr | output | 16 | Memory address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, valid combinationally |
| busy | output | 1 | High during read, write and update cycles |
| chanEn | output | 1 | Current channel enable |
| xferCount | output | 16 | Current transfer count |

## Verification
The assertions assume that software leaves the configuration port alone while a transfer is in flight. In particular, they assume the count and enable are not rewritten between a write cycle and the update it causes, and that the enable is only dropped through the final transfer, except where a configuration write is visible in the previous cycle. The stimulus always lets the engine go quiet before it reconfigures. It keeps each burst of back-to-back requests shorter than the pending limit, and it places source and destination windows in disjoint memory regions so that reads never see data the engine itself wrote. Random modes, sizes, counts and addresses come from a fixed seed. Directed cases cover the disabled-channel request, the 128-byte receive drain and a request that arrives after the final transfer.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_UPD,
    ST_DONE
  } xferState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic rdStb;
    logic wrStb;
    logic updStb;
    logic clrEn;
  } xferStrobes_t;

  // Mode word field positions
  localparam int SRC_LSB  = 0;
  localparam int DST_LSB  = 2;
  localparam int SIZE_BIT = 4;
  localparam int MODE_W   = 5;

  // Configuration select codes
  localparam logic [2:0] SEL_MODE = 3'd0;
  localparam logic [2:0] SEL_SRC  = 3'd1;
  localparam logic [2:0] SEL_DST  = 3'd2;
  localparam logic [2:0] SEL_CNT  = 3'd3;
  localparam logic [2:0] SEL_EN   = 3'd4;

endpackage

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [2:0]       cfgSel,
  input  logic [CFG_W-1:0] cfgData,
  input  xferStrobes_t     stb,
  input  logic [DW-1:0]    memRdata,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  output logic             memWide,
  output logic             chanEn,
  output logic [CW-1:0]    xferCount,
  output logic             cntZero
);

  localparam logic [AW-1:0] STEP_BYTE = AW'(1);
  localparam logic [AW-1:0] STEP_WORD = AW'(2);
  localparam logic [DW-1:0] BYTE_MASK = DW'(8'hFF);
  localparam logic [CW-1:0] CNT_ONE   = CW'(1);

  logic [MODE_W-1:0] modeReg;
  logic [AW-1:0]     srcReg;
  logic [AW-1:0]     dstReg;
  logic [CW-1:0]     cntReg;
  logic              enReg;
  logic [DW-1:0]     dataReg;
  logic [AW-1:0]     stepVal;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] addr,
                                            input logic [1:0] mode,
                                            input logic [AW-1:0] step);
    case (mode)
      2'b10:   return addr + step;
      2'b11:   return addr - step;
      default: return addr;
    endcase
  endfunction

  assign stepVal = modeReg[SIZE_BIT] ? STEP_WORD : STEP_BYTE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      srcReg  <= '0;
      dstReg  <= '0;
      cntReg  <= '0;
      enReg   <= 1'b0;
      dataReg <= '0;
    end else begin
      if (stb.rdStb) dataReg <= memRdata;
      if (stb.updStb) begin
        srcReg <= advance(srcReg, modeReg[SRC_LSB+:2], stepVal);
        dstReg <= advance(dstReg, modeReg[DST_LSB+:2], stepVal);
        cntReg <= cntReg - CNT_ONE;
      end
      if (stb.clrEn) begin
        enReg <= 1'b0;
      end else if (cfgWe && cfgSel == SEL_EN) begin
        enReg <= cfgData[0];
      end
      if (cfgWe) begin
        case (cfgSel)
          SEL_MODE: modeReg <= cfgData[MODE_W-1:0];
          SEL_SRC:  srcReg  <= cfgData[AW-1:0];
          SEL_DST:  dstReg  <= cfgData[AW-1:0];
          SEL_CNT:  cntReg  <= cfgData[CW-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign memAddr   = stb.wrStb ? dstReg : srcReg;
  assign memWdata  = modeReg[SIZE_BIT] ? dataReg : (dataReg & BYTE_MASK);
  assign memWide   = modeReg[SIZE_BIT];
  assign chanEn    = enReg;
  assign xferCount = cntReg;
  assign cntZero   = (cntReg == '0);

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqIn,
  input  logic         enIn,
  input  logic         cntZero,
  output xferStrobes_t stb,
  output logic         busy,
  output logic         flagClr,
  output logic         cpuIrq
);

  localparam logic [PW-1:0] PEND_MAX = '1;
  localparam logic [PW-1:0] PEND_ONE = PW'(1);

  xferState_t state, nextState;
  logic [PW-1:0] pend, pendNext;
  logic take;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pend  <= '0;
    end else begin
      state <= nextState;
      pend  <= pendNext;
    end
  end

  assign take = (state == ST_IDLE) && (pend != '0);

  always_comb begin
    pendNext = pend;
    if (reqIn && !take && pend != PEND_MAX) pendNext = pend + PEND_ONE;
    else if (!reqIn && take)                pendNext = pend - PEND_ONE;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: if (take && enIn) nextState = ST_RD;
      ST_RD:   nextState = ST_WR;
      ST_WR:   nextState = ST_UPD;
      ST_UPD:  nextState = ST_DONE;
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    stb.rdStb  = (state == ST_RD);
    stb.wrStb  = (state == ST_WR);
    stb.updStb = (state == ST_UPD);
    stb.clrEn  = (state == ST_DONE) && cntZero;
  end

  assign busy    = (state == ST_RD) || (state == ST_WR) || (state == ST_UPD);
  assign flagClr = (state == ST_DONE) && !cntZero;
  assign cpuIrq  = ((state == ST_DONE) && cntZero) || (take && !enIn);

endmodule

// File: rtl/irq_xfer_engine.sv
module irq_xfer_engine
  import xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int PW = 4,
  localparam int CFG_W = (AW > CW) ? AW : CW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [2:0]       cfgSel,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             reqIn,
  output logic             flagClr,
  output logic             cpuIrq,
  output logic             memRe,
  output logic             memWe,
  output logic             memWide,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  input  logic [DW-1:0]    memRdata,
  output logic             busy,
  output logic             chanEn,
  output logic [CW-1:0]    xferCount
);

  xferStrobes_t stb;
  logic cntZero;

  xfer_ctrl #(.PW(PW)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .enIn(chanEn), .cntZero(cntZero),
    .stb(stb), .busy(busy), .flagClr(flagClr), .cpuIrq(cpuIrq)
  );

  xfer_datapath #(.AW(AW), .DW(DW), .CW(CW), .CFG_W(CFG_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .stb(stb), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memWide(memWide), .chanEn(chanEn), .xferCount(xferCount), .cntZero(cntZero)
  );

  assign memRe = stb.rdStb;
  assign memWe = stb.wrStb;

endmodule

// File: rtl/irq_xfer_checker.sv
module irq_xfer_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          cfgWe,
  input logic          memRe,
  input logic          memWe,
  input logic          busy,
  input logic          flagClr,
  input logic          cpuIrq,
  input logic          chanEn,
  input logic [CW-1:0] xferCount
);

  // R8
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> memWe && busy && !memRe);

  // R8
  write_then_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> busy && !memRe && !memWe);

  // R7
  no_access_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> chanEn);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> ##1 (xferCount == $past(xferCount, 2) - 1'b1));

  // R5
  clear_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagClr |=> !flagClr);

  // R6
  clear_or_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(flagClr && cpuIrq));

  // R6
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(chanEn) && !$past(cfgWe)) |-> $past(cpuIrq));

endmodule

bind irq_xfer_engine irq_xfer_checker #(.CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .memRe(memRe), .memWe(memWe),
  .busy(busy), .flagClr(flagClr), .cpuIrq(cpuIrq), .chanEn(chanEn),
  .xferCount(xferCount)
);

// File: tb/tb_irq_xfer_engine.sv
`timescale 1ns/1ps
module tb_irq_xfer_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [15:0] cfgData = '0;
  logic        reqIn = 1'b0;
  logic        flagClr, cpuIrq, memRe, memWe, memWide, busy, chanEn;
  logic [15:0] memAddr, memWdata, memRdata, xferCount;

  always #2.5 clk = ~clk;

  irq_xfer_engine dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqIn(reqIn), .flagClr(flagClr), .cpuIrq(cpuIrq), .memRe(memRe),
    .memWe(memWe), .memWide(memWide), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .chanEn(chanEn), .xferCount(xferCount)
  );

  logic [15:0] mem [0:1023];
  assign memRdata = mem[memAddr[9:0]];
  always @(posedge clk) if (memWe) mem[memAddr[9:0]] <= memWdata;

  int total = 0, bad = 0;
  int rdCnt = 0, wrCnt = 0, clrCnt = 0, irqCnt = 0, busyRun = 0;
  logic [4:0]  curMode = '0;
  logic [15:0] expSrc = '0, expDst = '0, lastRd = '0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] stepAddr(input logic [15:0] a, input logic [1:0] m, input logic wide);
    case (m)
      2'b10:   return a + (wide ? 16'd2 : 16'd1);
      2'b11:   return a - (wide ? 16'd2 : 16'd1);
      default: return a;
    endcase
  endfunction

  // Port monitor
  always @(negedge clk) if (rstN) begin
    if (memRe) begin
      rdCnt++;
      check(memAddr == expSrc, "R3 source address", memAddr, expSrc);
      check(busy, "R8 busy during read", busy, 1);
      lastRd = mem[memAddr[9:0]];
    end
    if (memWe) begin
      logic [15:0] expData;
      wrCnt++;
      expData = curMode[4] ? lastRd : {8'h00, lastRd[7:0]};
      check(memAddr == expDst, "R3 destination address", memAddr, expDst);
      check(memWdata == expData, "R2 write data", memWdata, expData);
      check(memWide == curMode[4], "R2 access size", memWide, curMode[4]);
      expSrc = stepAddr(expSrc, curMode[1:0], curMode[4]);
      expDst = stepAddr(expDst, curMode[3:2], curMode[4]);
    end
    if (flagClr) clrCnt++;
    if (cpuIrq) irqCnt++;
    if (busy) busyRun++;
    else if (busyRun != 0) begin
      check(busyRun == 3, "R8 busy length", busyRun, 3);
      busyRun = 0;
    end
  end

  task automatic cfgWrite(input logic [2:0] sel, input logic [15:0] data);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic setup(input logic [4:0] mode, input logic [15:0] src,
                       input logic [15:0] dst, input logic [15:0] cnt);
    cfgWrite(3'd0, {11'd0, mode});   // R11 select codes
    cfgWrite(3'd1, src);
    cfgWrite(3'd2, dst);
    cfgWrite(3'd3, cnt);
    cfgWrite(3'd4, 16'd1);
    curMode = mode; expSrc = src; expDst = dst;
  endtask

  task automatic reqBurst(input int n);
    @(posedge clk); #1;
    reqIn = 1'b1;
    for (int k = 1; k < n; k++) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    reqIn = 1'b0;
  endtask

  task automatic waitIdle();
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0, w0, c0, i0;
    logic [7:0] sent [0:127];
    void'($urandom(32'd20240611));
    for (int a = 0; a < 1024; a++) mem[a] = 16'(a * 37 + 5);

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!chanEn, "R1 enable after reset", chanEn, 0);
    check(!busy && !memRe && !memWe, "R1 idle bus after reset", {busy, memRe, memWe}, 0);
    check(!flagClr && !cpuIrq, "R1 no strobes after reset", {flagClr, cpuIrq}, 0);
    check(xferCount == 0, "R1 count after reset", xferCount, 0);

    // R7 request with channel disabled
    r0 = rdCnt; c0 = clrCnt; i0 = irqCnt;
    reqBurst(1);
    waitIdle();
    check(irqCnt - i0 == 1, "R7 bypass interrupt", irqCnt - i0, 1);
    check(rdCnt == r0, "R7 no memory access", rdCnt - r0, 0);
    check(clrCnt == c0, "R7 no flag clear", clrCnt - c0, 0);

    // R10 128-byte drain, fixed source, incrementing destination, byte size
    setup(5'b01000, 16'h0040, 16'h0200, 16'd128);
    c0 = clrCnt; i0 = irqCnt;
    for (int i = 0; i < 128; i++) begin
      @(posedge clk); #1;
      mem[16'h0040] = 16'($urandom);
      sent[i] = mem[16'h0040][7:0];
      reqBurst(1);
      waitIdle();
    end
    for (int i = 0; i < 128; i++)
      check(mem[10'h200 + 10'(i)] == {8'h00, sent[i]}, "R10 destination byte",
            mem[10'h200 + 10'(i)], {8'h00, sent[i]});
    check(irqCnt - i0 == 1, "R10 single CPU interrupt", irqCnt - i0, 1);
    check(clrCnt - c0 == 127, "R10 flag clears", clrCnt - c0, 127);
    check(!chanEn && xferCount == 0, "R6 enable cleared at zero", {chanEn, xferCount}, 0);

    // Random modes, sizes, counts; alternate spaced and burst requests
    for (int t = 0; t < 24; t++) begin
      logic [4:0]  mode;
      logic [15:0] cnt;
      mode = 5'($urandom);
      cnt  = 16'($urandom_range(1, 5));
      setup(mode, 16'h0100 + 16'($urandom_range(0, 63)),
            16'h0300 + 16'($urandom_range(0, 63)), cnt);
      w0 = wrCnt; c0 = clrCnt; i0 = irqCnt;
      if (t % 2 == 1) begin
        reqBurst(int'(cnt));   // R9 back-to-back requests held pending
        waitIdle();
      end else begin
        for (int i = 0; i < int'(cnt); i++) begin
          reqBurst(1);
          waitIdle();
          check(xferCount == cnt - 16'(i + 1), "R4 count decrement", xferCount, cnt - 16'(i + 1));
          if (i + 1 < int'(cnt)) begin
            check(chanEn && irqCnt == i0, "R5 no interrupt mid-run", irqCnt - i0, 0);
            check(clrCnt - c0 == i + 1, "R5 flag clear per transfer", clrCnt - c0, i + 1);
          end
        end
      end
      check(wrCnt - w0 == int'(cnt), "R9 every request serviced", wrCnt - w0, cnt);
      check(clrCnt - c0 == int'(cnt) - 1, "R6 no clear on final", clrCnt - c0, cnt - 1);
      check(irqCnt - i0 == 1, "R6 one CPU interrupt", irqCnt - i0, 1);
      check(!chanEn, "R6 enable self-clears", chanEn, 0);
    end

    // R9 pending request outlives the final transfer and goes to the CPU
    setup(5'b11010, 16'h0180, 16'h0380, 16'd1);
    w0 = wrCnt; i0 = irqCnt; c0 = clrCnt;
    reqBurst(2);
    waitIdle();
    check(wrCnt - w0 == 1, "R9 single transfer", wrCnt - w0, 1);
    check(irqCnt - i0 == 2, "R9 final plus bypass interrupts", irqCnt - i0, 2);
    check(clrCnt == c0, "R7 no clear after disable", clrCnt - c0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule